// File: doc/BRIEF.md
# Dual-Pattern Serial Sequence Detector

This block watches a single-bit serial stream, taking one bit on each rising clock edge. It raises its match flag in the same cycle that the last bit of either of two four-bit patterns is present on the input: four ones in a row (1111) or a one, two zeros, then a one (1001). Occurrences may share bits, so a run of five ones produces two matches.

The block is a minimised Mealy machine with six states. The current state is kept in a register. The match flag is decoded combinationally from that state and the present input bit. A registered copy of the flag is also provided, one cycle later, for consumers that need a flopped signal. A synchronous reset returns the machine to its idle state.

Top module: `dual_seq_detect`

## Requirements
- R1: While `rst` is high at a rising edge, the machine returns to idle. In the cycle after that edge, with `din`=0, `hit` is 0 and `hit_q` is 0.
- R2: `hit` is 1 in a cycle exactly when the three bits taken on the previous three edges, followed by the current `din`, read 1111 (oldest first). This holds once at least three bits have been taken since reset.
- R3: `hit` is 1 in a cycle exactly when the three previous bits, followed by the current `din`, read 1001 (oldest first).
- R4: In all other cases `hit` is 0. This includes cycles in which fewer than three bits have been taken since reset.
- R5: Overlapping matches are all reported. A run of N ones (N≥4) gives N−3 consecutive matches, and 1001001 gives two matches.
- R6: `hit` depends on the current `din` within the same cycle. Changing `din` between edges changes `hit` without a clock edge.
- R7: `hit_q` equals the value `hit` had just before the previous rising edge. It is forced to 0 by reset.
- R8: The stream 010111100110011111 produces the match pattern 000000100100010011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial input bit |
| hit | output | 1 | Combinational match flag |
| hit_q | output | 1 | Registered match flag, one cycle later |

## Verification
The bench targets three kinds of corner case. The first is overlapping runs: long strings of ones, and chained 1001001. A non-overlapping design would drop the second match of each chain. The second is near misses such as 1101, 1011 and 10001. A state with the wrong zero-count memory would flag these falsely or lose track of the next one. The third is the first three bits after reset, where a machine that does not return to idle would report a stale match. Long pseudo-random streams are also compared against a four-bit shift-register model, to catch any wrong transition out of the seen-100 and seen-111 states.

// File: rtl/dual_seq_detect.sv
module dual_seq_detect (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit,
  output logic hit_q
);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_1    = 3'd1,
    ST_10   = 3'd2,
    ST_11   = 3'd3,
    ST_100  = 3'd4,
    ST_111  = 3'd5
  } state_t;

  state_t cur, nxt;

  always_comb begin
    nxt = ST_IDLE;
    case (cur)
      ST_IDLE: nxt = din ? ST_1   : ST_IDLE;
      ST_1:    nxt = din ? ST_11  : ST_10;
      ST_10:   nxt = din ? ST_1   : ST_100;
      ST_11:   nxt = din ? ST_111 : ST_10;
      ST_100:  nxt = din ? ST_1   : ST_IDLE;
      ST_111:  nxt = din ? ST_111 : ST_10;
      default: nxt = ST_IDLE;
    endcase
  end

  assign hit = din & ((cur == ST_100) | (cur == ST_111));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= ST_IDLE;
      hit_q <= 1'b0;
    end else begin
      cur   <= nxt;
      hit_q <= hit;
    end
  end

endmodule

module dual_seq_detect_chk (
  input logic clk,
  input logic rst,
  input logic din,
  input logic hit,
  input logic hit_q
);

  logic [2:0] hist;
  logic [1:0] fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= 3'b000;
      fill <= 2'd0;
    end else begin
      hist <= {hist[1:0], din};
      if (fill != 2'd3) fill <= fill + 2'd1;
    end
  end

  AST_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (fill == 2'd3 && hist == 3'b111 && din) |-> hit); // R2
  AST_ONE_ZZ_ONE: assert property (@(posedge clk) disable iff (rst)
    (fill == 2'd3 && hist == 3'b100 && din) |-> hit); // R3
  AST_NO_FALSE_HIT: assert property (@(posedge clk) disable iff (rst)
    hit |-> (fill == 2'd3 && din && (hist == 3'b111 || hist == 3'b100))); // R4
  AST_ZERO_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    !din |-> !hit); // R6
  AST_HITQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (hit_q == $past(hit))); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> !hit_q); // R1

endmodule

bind dual_seq_detect dual_seq_detect_chk u_chk (
  .clk(clk), .rst(rst), .din(din), .hit(hit), .hit_q(hit_q)
);

// File: tb/dual_seq_detect_test.sv
`timescale 1ns/1ps
module dual_seq_detect_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit, hit_q;

  int n_cmp = 0;
  int n_bad = 0;
  logic [2:0] ref_hist;
  int ref_fill;
  logic ref_prev_hit;
  bit   ref_prev_valid;

  dual_seq_detect uut (.clk(clk), .rst(rst), .din(din), .hit(hit), .hit_q(hit_q));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic model_hit(input logic b);
    return (ref_fill >= 3) && b && (ref_hist == 3'b111 || ref_hist == 3'b100);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; din = 1'b0;
    @(negedge clk); rst = 1'b0;
    ref_hist = 3'b000; ref_fill = 0; ref_prev_valid = 1'b0;
  endtask

  // Drive one bit at the negedge and check hit, and hit_q from the prior bit.
  task automatic push(input logic b, input string req);
    din = b;
    #1;
    check(req, hit, model_hit(b));
    if (ref_prev_valid) check("R7", hit_q, ref_prev_hit);
    ref_prev_hit = model_hit(b);
    ref_prev_valid = 1'b1;
    @(posedge clk);
    ref_hist = {ref_hist[1:0], b};
    if (ref_fill < 3) ref_fill++;
    @(negedge clk);
  endtask

  task automatic push_str(input string s, input string req);
    for (int i = 0; i < s.len(); i++) push(s[i] == "1", req);
  endtask

  task automatic t_reset();
    do_reset();
    din = 1'b0; #1;
    check("R1", hit, 1'b0);
    check("R1", hit_q, 1'b0);
    push_str("111", "R4");
    push(1'b1, "R2");
    do_reset();
    #1;
    check("R1", hit_q, 1'b0);
    push_str("100", "R4");
    push(1'b1, "R3");
  endtask

  task automatic t_example();
    string s = "010111100110011111";
    string e = "000000100100010011";
    do_reset();
    for (int i = 0; i < s.len(); i++) begin
      din = (s[i] == "1"); #1;
      check("R8", hit, e[i] == "1");
      push(s[i] == "1", "R8");
    end
  endtask

  task automatic t_overlap();
    int cnt = 0;
    do_reset();
    for (int i = 0; i < 9; i++) begin
      din = 1'b1; #1;
      if (hit) cnt++;
      push(1'b1, "R5");
    end
    check("R5", cnt == 6, 1'b1);
    do_reset();
    cnt = 0;
    for (int i = 0; i < 7; i++) begin
      logic b = (i % 3) == 0;
      din = b; #1;
      if (hit) cnt++;
      push(b, "R5");
    end
    check("R5", cnt == 2, 1'b1);
  endtask

  task automatic t_near_miss();
    do_reset();
    push_str("1101", "R4");
    push_str("0", "R4");
    push_str("1011", "R4");
    push_str("0", "R4");
    push_str("10001", "R4");
    push_str("0110111", "R4");
  endtask

  task automatic t_comb();
    do_reset();
    push_str("100", "R3");
    din = 1'b1; #1; check("R6", hit, 1'b1);
    din = 1'b0; #1; check("R6", hit, 1'b0);
    din = 1'b1; #1; check("R6", hit, 1'b1);
    push(1'b1, "R3");
  endtask

  task automatic t_random();
    logic [15:0] lfsr = 16'hACE1;
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      push(lfsr[0] | (lfsr[3] & (i % 7 < 4)), "R2/R3/R4");
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_example();
        t_overlap();
        t_near_miss();
        t_comb();
        t_random();
      end
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule